// File: doc/BRIEF.md
# Power-Up Strap Capture and Clock Output Gating

This block sits between the frequency synthesis core of a clock generator and its output pins. At power-on several pins do double duty: while the supply ramps they are inputs that set the board's configuration, and afterwards they carry clocks. The block records those configuration levels once, when power-good first rises. It then drives every clock pin low for a programmable settling interval. After that it opens each clock output according to its enable bit, without cutting any clock pulse short.

One latched configuration bit, the role strap, decides what a shared pin does. When the strap is high the pin carries a reference clock. When it is low the pin is an active-low power-down input, and while that input is low every clock is parked low except the one free-running processor clock. The block also picks the frequency-select code the synthesizer uses: either the four latched hardware strap bits or a six-bit code written by software.

Top module: `clkgen_ctl`

## Requirements
- R1: While reset is asserted and until power-good first rises, every output enable `clk_oe` is 0, every `clk_out` is 0 and `strap_valid` is 0.
- R2: On the first cycle in which `pwr_good` is seen high after reset, `strap_in` is captured into `strap_val` (bit 4 is the role strap, bits 3:0 the hardware select code), and `strap_valid` becomes 1. From the next cycle on, all lanes (lanes 0 to 4 share the strap pins) are driven as outputs, with `clk_oe` high and `clk_out` low.
- R3: After the capture, all clock outputs stay low for `TIMER_TC` cycles of `clk`. After that, enabled lanes follow their source.
- R4: Once captured, `strap_val` never changes until the next reset, whatever `strap_in` or further `pwr_good` edges do.
- R5: With role strap 1, lane `PIN2_IDX` is a clock output and `pd_n_in` has no effect. With role strap 0, lane `PIN2_IDX` has `clk_oe` = 0 and `clk_out` = 0, and `pd_n_in` is the power-down input.
- R6: With role strap 0 and `pd_n_in` low, every lane except `FREE_IDX` is parked low, and lane `FREE_IDX` keeps following its source.
- R7: `freq_sel` equals `sw_code` when `sw_sel` = 1. It equals {2'b00, `strap_val[3:0]`} when `sw_sel` = 0, because the 16 hardware entries match the first 16 software entries.
- R8: `tri_all` = 1 forces every `clk_oe` to 0 once straps are captured, and the clocks keep being gated internally.
- R9: In the run phase, a lane whose `clk_en` bit is 1 follows `clk_src`. A lane whose bit is 0 is held at 0.
- R10: A change of a lane's run state takes effect only while that lane's source is low. An output therefore never rises or falls except together with its source, so no shortened pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock that samples straps, runs the timer and retimes gating |
| rst | input | 1 | Synchronous active-high reset (true power-on) |
| pwr_good | input | 1 | Supply has crossed its threshold; first rise captures straps |
| strap_in | input | 5 | Levels on the dual-function pins; bit 4 role strap, bits 3:0 select code |
| pd_n_in | input | 1 | Active-low power-down, used only when role strap is 0 |
| clk_src | input | NCLK | Divided clock sources, one per lane |
| clk_en | input | NCLK | Per-lane run (1) / stop (0) bits |
| sw_sel | input | 1 | 0: hardware strap code, 1: software code |
| tri_all | input | 1 | 1: release every output to high impedance |
| sw_code | input | 6 | Software frequency-select code |
| clk_out | output | NCLK | Gated clocks |
| clk_oe | output | NCLK | Per-lane output drive enables |
| strap_val | output | 5 | Captured strap levels |
| strap_valid | output | 1 | Straps have been captured |
| freq_sel | output | 6 | Active frequency-select code |

## Verification
The bench builds the block with `TIMER_TC` = 8 instead of the default of about 43 thousand. This brings the end of the settling interval and the whole run phase within a few dozen cycles, so the hold-low window can be checked cycle by cycle. `NCLK` = 8, `PIN2_IDX` = 5 and `FREE_IDX` = 6 keep the shared-pin lane and the free-running lane distinct from each other and from the strap lanes. The block is brought up twice, once with each role strap value, so that both the clock role and the power-down role of the shared pin are exercised.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int STRAP_W = 5;
    localparam int FS_W    = 4;
    localparam int CODE_W  = 6;

    typedef enum logic [1:0] {
        PH_INPUT = 2'd0,
        PH_HOLD  = 2'd1,
        PH_RUN   = 2'd2
    } phase_t;

    typedef struct packed {
        logic            role;
        logic [FS_W-1:0] fs;
    } strap_t;

    function automatic logic [CODE_W-1:0] hw_code(input logic [FS_W-1:0] fs);
        return {{(CODE_W-FS_W){1'b0}}, fs};
    endfunction

endpackage

// File: rtl/strap_seq.sv
module strap_seq
    import clkctl_pkg::*;
#(
    parameter int TIMER_TC = 42954
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_good,
    input  logic [STRAP_W-1:0] strap_in,
    output phase_t             phase,
    output strap_t             straps
);
    localparam int CW = $clog2(TIMER_TC + 1);

    logic          pg_q;
    logic [CW-1:0] tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_INPUT;
            straps <= '0;
            tick   <= '0;
            pg_q   <= 1'b0;
        end else begin
            pg_q <= pwr_good;
            case (phase)
                PH_INPUT: begin
                    if (pwr_good && !pg_q) begin
                        straps <= strap_t'(strap_in);
                        phase  <= PH_HOLD;
                        tick   <= '0;
                    end
                end
                PH_HOLD: begin
                    if (tick == CW'(TIMER_TC - 1)) phase <= PH_RUN;
                    else                           tick  <= tick + 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/clk_lane.sv
module clk_lane (
    input  logic clk,
    input  logic rst,
    input  logic src,
    input  logic want,
    output logic out
);
    logic run_q;

    // run state may only move while the source sits low
    always_ff @(posedge clk) begin
        if (rst)       run_q <= 1'b0;
        else if (!src) run_q <= want;
    end

    assign out = src & run_q;

endmodule

// File: rtl/freq_mux.sv
module freq_mux
    import clkctl_pkg::*;
(
    input  logic              sw_sel,
    input  logic [CODE_W-1:0] sw_code,
    input  logic [FS_W-1:0]   fs,
    output logic [CODE_W-1:0] freq_sel
);
    always_comb begin
        freq_sel = sw_sel ? sw_code : hw_code(fs);
    end

endmodule

// File: rtl/clkgen_ctl.sv
module clkgen_ctl
    import clkctl_pkg::*;
#(
    parameter int NCLK     = 8,
    parameter int PIN2_IDX = 5,
    parameter int FREE_IDX = 6,
    parameter int TIMER_TC = 42954
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_good,
    input  logic [STRAP_W-1:0] strap_in,
    input  logic               pd_n_in,
    input  logic [NCLK-1:0]    clk_src,
    input  logic [NCLK-1:0]    clk_en,
    input  logic               sw_sel,
    input  logic               tri_all,
    input  logic [CODE_W-1:0]  sw_code,
    output logic [NCLK-1:0]    clk_out,
    output logic [NCLK-1:0]    clk_oe,
    output logic [STRAP_W-1:0] strap_val,
    output logic               strap_valid,
    output logic [CODE_W-1:0]  freq_sel
);
    phase_t          phase;
    strap_t          straps;
    logic [NCLK-1:0] want;
    logic            in_run;
    logic            pd_act;

    strap_seq #(.TIMER_TC(TIMER_TC)) seq_i (
        .clk      (clk),
        .rst      (rst),
        .pwr_good (pwr_good),
        .strap_in (strap_in),
        .phase    (phase),
        .straps   (straps)
    );

    assign in_run      = (phase == PH_RUN);
    assign strap_valid = (phase != PH_INPUT);
    assign strap_val   = straps;
    assign pd_act      = !straps.role && !pd_n_in;

    for (genvar i = 0; i < NCLK; i++) begin : g_lane
        localparam bit IS_PIN2 = (i == PIN2_IDX);
        localparam bit IS_FREE = (i == FREE_IDX);

        logic pin_is_input;
        assign pin_is_input = IS_PIN2 && !straps.role;

        assign want[i] = in_run && clk_en[i] && !pin_is_input
                         && !(pd_act && !IS_FREE);

        assign clk_oe[i] = strap_valid && !tri_all && !pin_is_input;

        clk_lane lane_i (
            .clk  (clk),
            .rst  (rst),
            .src  (clk_src[i]),
            .want (want[i]),
            .out  (clk_out[i])
        );
    end

    freq_mux mux_i (
        .sw_sel   (sw_sel),
        .sw_code  (sw_code),
        .fs       (straps.fs),
        .freq_sel (freq_sel)
    );

endmodule

// File: rtl/clkgen_ctl_chk.sv
module clkgen_ctl_chk #(
    parameter int NCLK     = 8,
    parameter int PIN2_IDX = 5,
    parameter int FREE_IDX = 6,
    parameter int TIMER_TC = 42954
) (
    input logic            clk,
    input logic            rst,
    input logic            pd_n_in,
    input logic [NCLK-1:0] clk_src,
    input logic            sw_sel,
    input logic            tri_all,
    input logic [5:0]      sw_code,
    input logic [NCLK-1:0] clk_out,
    input logic [NCLK-1:0] clk_oe,
    input logic [4:0]      strap_val,
    input logic            strap_valid,
    input logic [5:0]      freq_sel
);
    logic [31:0] since_cap;
    logic        pd_seen;

    always_ff @(posedge clk) begin
        if (rst)                                    since_cap <= '0;
        else if (strap_valid && since_cap < TIMER_TC) since_cap <= since_cap + 1;
    end

    assign pd_seen = strap_valid && !strap_val[4] && !pd_n_in;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (clk_oe == '0 && !strap_valid));

    // R2
    no_drive_before_cap_chk: assert property (@(posedge clk) disable iff (rst)
        !strap_valid |-> (clk_oe == '0 && clk_out == '0));

    // R3
    hold_low_chk: assert property (@(posedge clk) disable iff (rst)
        (strap_valid && since_cap < TIMER_TC) |-> clk_out == '0);

    // R4
    straps_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (strap_valid && $past(strap_valid)) |-> $stable(strap_val));

    // R5
    pin2_input_chk: assert property (@(posedge clk) disable iff (rst)
        (strap_valid && !strap_val[4]) |-> (!clk_oe[PIN2_IDX] && !clk_out[PIN2_IDX]));

    // R7
    hw_select_chk: assert property (@(posedge clk) disable iff (rst)
        !sw_sel |-> (freq_sel[5:4] == 2'b00 && freq_sel[3:0] == strap_val[3:0]));

    // R8
    tri_all_chk: assert property (@(posedge clk) disable iff (rst)
        tri_all |-> clk_oe == '0);

    for (genvar i = 0; i < NCLK; i++) begin : g_lane_chk
        // R10
        rise_with_src_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(clk_out[i]) |-> $rose(clk_src[i]));
        // R10
        fall_with_src_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(clk_out[i]) |-> $fell(clk_src[i]));
        if (i != FREE_IDX) begin : g_pd
            // R6
            pd_parks_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(clk_out[i]) |-> !$past(pd_seen));
        end
    end

endmodule

bind clkgen_ctl clkgen_ctl_chk #(
    .NCLK(NCLK), .PIN2_IDX(PIN2_IDX), .FREE_IDX(FREE_IDX), .TIMER_TC(TIMER_TC)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .pd_n_in     (pd_n_in),
    .clk_src     (clk_src),
    .sw_sel      (sw_sel),
    .tri_all     (tri_all),
    .sw_code     (sw_code),
    .clk_out     (clk_out),
    .clk_oe      (clk_oe),
    .strap_val   (strap_val),
    .strap_valid (strap_valid),
    .freq_sel    (freq_sel)
);

// File: tb/clkgen_ctl_tb_top.sv
module clkgen_ctl_tb_top;
    localparam int NCLK = 8;
    localparam int P2   = 5;
    localparam int FR   = 6;
    localparam int TC   = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            pwr_good = 1'b0;
    logic [4:0]      strap_in = '0;
    logic            pd_n_in = 1'b1;
    logic [NCLK-1:0] clk_en = '1;
    logic            sw_sel = 1'b0;
    logic            tri_all = 1'b0;
    logic [5:0]      sw_code = '0;
    logic [NCLK-1:0] clk_out, clk_oe;
    logic [4:0]      strap_val;
    logic            strap_valid;
    logic [5:0]      freq_sel;
    logic [7:0]      sc = '0;
    logic [NCLK-1:0] clk_src;
    int              checks = 0;
    int              errors = 0;
    bit              done = 0;

    always #4 clk = ~clk;
    always @(negedge clk) sc <= sc + 1'b1;
    assign clk_src = {NCLK{sc[1]}};

    clkgen_ctl #(.NCLK(NCLK), .PIN2_IDX(P2), .FREE_IDX(FR), .TIMER_TC(TC)) dut_i (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .strap_in(strap_in),
        .pd_n_in(pd_n_in), .clk_src(clk_src), .clk_en(clk_en), .sw_sel(sw_sel),
        .tri_all(tri_all), .sw_code(sw_code), .clk_out(clk_out), .clk_oe(clk_oe),
        .strap_val(strap_val), .strap_valid(strap_valid), .freq_sel(freq_sel)
    );

    // {en[8], sw_sel, tri_all, sw_code[6], pd_n, exp_sel[6], exp_oe[8], exp_run[8]}
    localparam logic [38:0] VEC [5] = '{
        {8'hFF, 1'b0, 1'b0, 6'h2A, 1'b1, 6'h06, 8'hFF, 8'hFF},
        {8'h5A, 1'b1, 1'b0, 6'h2A, 1'b1, 6'h2A, 8'hFF, 8'h5A},
        {8'hFF, 1'b1, 1'b1, 6'h3F, 1'b1, 6'h3F, 8'h00, 8'hFF},
        {8'h00, 1'b0, 1'b0, 6'h15, 1'b1, 6'h06, 8'hFF, 8'h00},
        {8'hFF, 1'b0, 1'b0, 6'h00, 1'b0, 6'h06, 8'hFF, 8'hFF}
    };
    string vtag [5] = '{"R7", "R9", "R8", "R9", "R5"};

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sample();
        @(posedge clk);
        #2;
    endtask

    task automatic window(input logic [NCLK-1:0] run, input string req);
        for (int k = 0; k < 8; k++) begin
            sample();
            check(clk_out == (clk_src & run), req, 32'(clk_out), 32'(clk_src & run));
        end
    endtask

    task automatic boot(input logic [4:0] straps);
        @(negedge clk);
        rst = 1'b1; pwr_good = 1'b0; strap_in = straps;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        sample();
        check(clk_oe == '0 && clk_out == '0 && !strap_valid, "R1",
              {clk_oe, clk_out, 7'd0, strap_valid}, 32'd0);
        @(negedge clk);
        pwr_good = 1'b1;
        sample();
        check(strap_valid && strap_val == straps, "R2",
              {strap_valid, strap_val}, {1'b1, straps});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // first power-up: role strap 1, hardware code 6
        boot(5'b1_0110);
        check(clk_oe == 8'hFF && clk_out == '0, "R2", {clk_oe, clk_out}, 16'hFF00);
        // R3: hold low for the whole interval, R4: disturb the straps meanwhile
        for (int k = 0; k < TC - 1; k++) begin
            if (k == 2) begin strap_in = 5'b0_1001; pwr_good = 1'b0; end
            if (k == 4) pwr_good = 1'b1;
            sample();
            check(clk_out == '0, "R3", 32'(clk_out), 32'd0);
        end
        repeat (6) sample();
        check(strap_val == 5'b1_0110, "R4", 32'(strap_val), 32'h16);
        window('1, "R3");

        foreach (VEC[n]) begin
            @(negedge clk);
            clk_en  = VEC[n][38:31];
            sw_sel  = VEC[n][30];
            tri_all = VEC[n][29];
            sw_code = VEC[n][28:23];
            pd_n_in = VEC[n][22];
            repeat (6) sample();
            check(freq_sel == VEC[n][21:16], "R7", 32'(freq_sel), 32'(VEC[n][21:16]));
            check(clk_oe == VEC[n][15:8], vtag[n], 32'(clk_oe), 32'(VEC[n][15:8]));
            window(VEC[n][7:0], vtag[n]);
        end

        // R10: stop requested while source high is deferred
        @(negedge clk);
        clk_en = '1; sw_sel = 1'b0; tri_all = 1'b0; pd_n_in = 1'b1;
        repeat (6) sample();
        do begin @(posedge clk); #1; end while (sc[1:0] != 2'd2);
        clk_en[0] = 1'b0;
        sample();
        check(clk_out[0] == 1'b1, "R10 stop deferred", 32'(clk_out[0]), 32'd1);
        repeat (4) sample();
        check(clk_out[0] == 1'b0 && clk_src[0], "R10 stopped", 32'(clk_out[0]), 32'd0);
        do begin @(posedge clk); #1; end while (sc[1:0] != 2'd2);
        clk_en[0] = 1'b1;
        sample();
        check(clk_out[0] == 1'b0, "R10 start deferred", 32'(clk_out[0]), 32'd0);
        repeat (4) sample();
        check(clk_out[0] == 1'b1 && clk_src[0], "R10 started", 32'(clk_out[0]), 32'd1);

        // second power-up: role strap 0, hardware code 3
        boot(5'b0_0011);
        repeat (TC + 6) sample();
        check(clk_oe == 8'hDF, "R5", 32'(clk_oe), 32'hDF);
        check(freq_sel == 6'h03, "R7", 32'(freq_sel), 32'h03);
        window(8'hDF, "R9");
        @(negedge clk);
        pd_n_in = 1'b0;
        repeat (6) sample();
        window(8'h40, "R6");
        check(clk_oe == 8'hDF, "R6 pins still driven", 32'(clk_oe), 32'hDF);
        @(negedge clk);
        pd_n_in = 1'b1;
        repeat (6) sample();
        window(8'hDF, "R6 resume");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule